// File: doc/BRIEF.md
# Audio DSP Control and Interrupt Register

This block is a single 16-bit control and status word placed between a host processor and an audio DSP subsystem. It collects three interrupt sources: the DSP signalling the host, completion of an auxiliary-memory DMA transfer, and completion of an audio DMA transfer. Each source has a sticky status bit and a separate enable (mask) bit. The combined, masked result drives one interrupt line toward the host.

The same word also controls the DSP. Through it the host can hold the DSP halted, raise an interrupt toward it, choose the address the DSP starts from after a reset, and start a reset. The reset is self-timed and its bit reads back as zero once the sequence is over. Two read-only bits report whether the auxiliary-memory DMA or the DSP DMA is busy. The host reaches the word through a plain write strobe with write data and a combinational read bus. The DMA engines and the DSP deliver one-cycle event pulses and level busy signals.

Top module: `dsp_ctl_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x0000 in every bit except bits 9 and 10, which follow the busy inputs, and `cpu_irq`, `dsp_reset`, `dsp_halt`, `dsp_kick` and `dsp_vec_hi` are all low.
- R2: A one-cycle pulse on a source event input sets that source's status bit, which reads as 1 from the next cycle. The status bits are: bit 3 for audio DMA done, bit 5 for auxiliary DMA done, and bit 7 for DSP-to-host.
- R3: Writing 1 to a status bit (3, 5 or 7) clears it in the next cycle. Writing 0 to it leaves it unchanged.
- R4: If an event pulse and a write-1 clear hit the same status bit in the same cycle, the bit is set afterwards.
- R5: Mask bits 4, 6 and 8 (for the sources at bits 3, 5 and 7) are plain read/write bits. `cpu_irq` is high exactly when some status bit and its mask bit are both 1.
- R6: Writing 1 to bit 0 while no reset is running makes bit 0 and `dsp_reset` read 1 for exactly RESET_CYCLES (default 8) cycles, after which they read 0. Writes to bit 0 while a reset is running have no effect. Writing 0 to bit 0 while no reset is running does not start one.
- R7: Bit 1 (host-to-DSP interrupt, `dsp_kick`), bit 2 (halt, `dsp_halt`) and bit 11 (start vector: 1 selects 0x8000, 0 selects 0x0000, `dsp_vec_hi`) are read/write bits. Each drives its output from the cycle after the write.
- R8: Bit 9 reads `busy_aux_dma` and bit 10 reads `busy_dsp_dma`. Writes to these bits are ignored.
- R9: Bits 12 to 15 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register value |
| evt_aud_dma | input | 1 | Audio DMA done pulse |
| evt_aux_dma | input | 1 | Auxiliary-memory DMA done pulse |
| evt_dsp | input | 1 | DSP-to-host interrupt pulse |
| busy_aux_dma | input | 1 | Auxiliary-memory DMA in progress |
| busy_dsp_dma | input | 1 | DSP DMA in progress |
| cpu_irq | output | 1 | Combined masked interrupt to the host |
| dsp_reset | output | 1 | DSP held in reset |
| dsp_halt | output | 1 | DSP halted |
| dsp_kick | output | 1 | Host-to-DSP interrupt |
| dsp_vec_hi | output | 1 | Reset start address select (1 means 0x8000) |

## Verification
Two pairs of events can land in the same cycle. One is a source event pulse together with a host write-1 clear on the same status bit. The other is a write to bit 0 in the cycle where the running reset expires. The bench forces the first pair in a directed step and checks that the status bit stays set and the interrupt line stays high. It then produces both pairs many times with sparse random traffic. A behavioural model resolves each collision by the stated rules (set wins; a write arriving before the reset has finished is dropped), and every output is compared with the model on every clock.

// File: rtl/dsp_ctl_pkg.sv
package dsp_ctl_pkg;
   localparam int REG_W      = 16;
   localparam int NUM_SRC    = 3;
   localparam int BIT_RESET  = 0;
   localparam int BIT_KICK   = 1;
   localparam int BIT_HALT   = 2;
   localparam int BIT_SRC0   = 3;   // status of source i at BIT_SRC0+2i, mask at +1
   localparam int BIT_BUSY_A = 9;
   localparam int BIT_BUSY_D = 10;
   localparam int BIT_VEC    = 11;
   localparam int BIT_TOP    = 12;
endpackage

// File: rtl/dsp_irq_cell.sv
module dsp_irq_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_clr,
   input  logic wr_msk,
   input  logic evt,
   output logic st,
   output logic msk
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= 1'b0;
         msk <= 1'b0;
      end else begin
         if (evt)                  st <= 1'b1;
         else if (wr_en && wr_clr) st <= 1'b0;
         if (wr_en)                msk <= wr_msk;
      end
   end

   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> st);
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_clr && !evt) |=> !st);
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt && !(wr_en && wr_clr)) |=> (st == $past(st)));
   p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (msk == $past(wr_msk)));
endmodule

// File: rtl/dsp_reset_seq.sv
module dsp_reset_seq #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

   initial begin
      if (CYCLES < 2) $error("dsp_reset_seq: CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= LOAD;
      end
   end

   p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |=> busy);
   p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !busy);
endmodule

// File: rtl/dsp_ctl_reg.sv
module dsp_ctl_reg
   import dsp_ctl_pkg::*;
#(
   parameter int RESET_CYCLES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             evt_aud_dma,
   input  logic             evt_aux_dma,
   input  logic             evt_dsp,
   input  logic             busy_aux_dma,
   input  logic             busy_dsp_dma,
   output logic             cpu_irq,
   output logic             dsp_reset,
   output logic             dsp_halt,
   output logic             dsp_kick,
   output logic             dsp_vec_hi
);
   initial begin
      if (BIT_SRC0 + 2*NUM_SRC != BIT_BUSY_A)
         $error("dsp_ctl_reg: source bits overlap busy flags");
   end

   logic [NUM_SRC-1:0] evt_vec, st_vec, msk_vec;
   assign evt_vec = {evt_dsp, evt_aux_dma, evt_aud_dma};

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      dsp_irq_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr_en),
         .wr_clr (wr_data[BIT_SRC0 + 2*i]),
         .wr_msk (wr_data[BIT_SRC0 + 2*i + 1]),
         .evt    (evt_vec[i]),
         .st     (st_vec[i]),
         .msk    (msk_vec[i])
      );
   end

   dsp_reset_seq #(.CYCLES(RESET_CYCLES)) u_rst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_en && wr_data[BIT_RESET]),
      .busy  (dsp_reset)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dsp_halt   <= 1'b0;
         dsp_kick   <= 1'b0;
         dsp_vec_hi <= 1'b0;
      end else if (wr_en) begin
         dsp_halt   <= wr_data[BIT_HALT];
         dsp_kick   <= wr_data[BIT_KICK];
         dsp_vec_hi <= wr_data[BIT_VEC];
      end
   end

   assign cpu_irq = |(st_vec & msk_vec);

   always_comb begin
      rd_data             = '0;
      rd_data[BIT_RESET]  = dsp_reset;
      rd_data[BIT_KICK]   = dsp_kick;
      rd_data[BIT_HALT]   = dsp_halt;
      for (int i = 0; i < NUM_SRC; i++) begin
         rd_data[BIT_SRC0 + 2*i]     = st_vec[i];
         rd_data[BIT_SRC0 + 2*i + 1] = msk_vec[i];
      end
      rd_data[BIT_BUSY_A] = busy_aux_dma;
      rd_data[BIT_BUSY_D] = busy_dsp_dma;
      rd_data[BIT_VEC]    = dsp_vec_hi;
   end

   p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq == ((rd_data[3] & rd_data[4]) | (rd_data[5] & rd_data[6]) |
                  (rd_data[7] & rd_data[8])));
   p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[10:9] == {busy_dsp_dma, busy_aux_dma});
   p_top_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[REG_W-1:BIT_TOP] == '0);
   p_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (dsp_halt == $past(wr_data[BIT_HALT]) &&
                 dsp_vec_hi == $past(wr_data[BIT_VEC])));
endmodule

// File: tb/dsp_ctl_reg_tb.sv
`timescale 1ns/100ps
module dsp_ctl_reg_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic evt_aud_dma = 1'b0, evt_aux_dma = 1'b0, evt_dsp = 1'b0;
   logic busy_aux_dma = 1'b0, busy_dsp_dma = 1'b0;
   logic cpu_irq, dsp_reset, dsp_halt, dsp_kick, dsp_vec_hi;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   dsp_ctl_reg u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .evt_aud_dma(evt_aud_dma), .evt_aux_dma(evt_aux_dma), .evt_dsp(evt_dsp),
      .busy_aux_dma(busy_aux_dma), .busy_dsp_dma(busy_dsp_dma), .cpu_irq(cpu_irq),
      .dsp_reset(dsp_reset), .dsp_halt(dsp_halt), .dsp_kick(dsp_kick),
      .dsp_vec_hi(dsp_vec_hi)
   );

   // behavioural reference model
   bit m_st[3];
   bit m_msk[3];
   bit m_halt, m_kick, m_vec;
   int m_rleft;

   function automatic bit m_evt(int i);
      case (i)
         0: return evt_aud_dma;
         1: return evt_aux_dma;
         default: return evt_dsp;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_st[i]) begin m_st[i] = 0; m_msk[i] = 0; end
         m_halt = 0; m_kick = 0; m_vec = 0; m_rleft = 0;
      end else begin
         for (int i = 0; i < 3; i++) begin
            if (m_evt(i)) m_st[i] = 1;
            else if (wr_en && wr_data[3 + 2*i]) m_st[i] = 0;
            if (wr_en) m_msk[i] = wr_data[4 + 2*i];
         end
         if (wr_en) begin
            m_halt = wr_data[2]; m_kick = wr_data[1]; m_vec = wr_data[11];
         end
         if (m_rleft > 0) m_rleft = m_rleft - 1;
         else if (wr_en && wr_data[0]) m_rleft = 8;
      end
   end

   task automatic check(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit irq_exp;
         irq_exp = 0;
         for (int i = 0; i < 3; i++) begin
            check("R2 status", rd_data[3 + 2*i], m_st[i]);
            check("R5 mask", rd_data[4 + 2*i], m_msk[i]);
            irq_exp |= m_st[i] & m_msk[i];
         end
         check("R5 cpu_irq", cpu_irq, irq_exp);
         check("R6 reset bit", rd_data[0], m_rleft > 0);
         check("R6 dsp_reset", dsp_reset, m_rleft > 0);
         check("R7 ctrl", {rd_data[11], rd_data[2], rd_data[1]}, {m_vec, m_halt, m_kick});
         check("R7 outputs", {dsp_vec_hi, dsp_halt, dsp_kick}, {m_vec, m_halt, m_kick});
         check("R8 busy", rd_data[10:9], {busy_dsp_dma, busy_aux_dma});
         check("R9 top", rd_data[15:12], 0);
      end
   end

   task automatic step(bit we, logic [15:0] wd, logic [2:0] ev, logic [1:0] bz);
      @(negedge clk);
      #1;
      wr_en = we; wr_data = wd;
      {evt_dsp, evt_aux_dma, evt_aud_dma} = ev;
      {busy_dsp_dma, busy_aux_dma} = bz;
   endtask

   task automatic idle();
      step(0, 16'h0, 3'b0, 2'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rd_data", rd_data, 16'h0000);
      check("R1 outputs", {cpu_irq, dsp_reset, dsp_halt, dsp_kick, dsp_vec_hi}, 0);

      step(0, 16'h0, 3'b001, 2'b0);       // audio DMA event
      idle();
      @(negedge clk);
      check("R2 set bit3", rd_data[3], 1);
      check("R5 masked irq", cpu_irq, 0);
      step(1, 16'h0010, 3'b0, 2'b0);       // enable mask, write 0 to status
      idle();
      @(negedge clk);
      check("R3 write0 keeps", rd_data[3], 1);
      check("R5 irq on", cpu_irq, 1);
      step(1, 16'h0018, 3'b001, 2'b0);     // clear collides with event
      idle();
      @(negedge clk);
      check("R4 set wins", rd_data[3], 1);
      check("R4 irq stays", cpu_irq, 1);
      step(1, 16'h0018, 3'b0, 2'b0);
      idle();
      @(negedge clk);
      check("R3 write1 clears", rd_data[3], 0);
      check("R5 irq off", cpu_irq, 0);

      step(1, 16'h0001, 3'b0, 2'b0);       // start DSP reset
      step(1, 16'h0000, 3'b0, 2'b0);       // ignored while running
      for (int k = 0; k < 6; k++) idle();
      @(negedge clk);
      check("R6 still set at 8th cycle", rd_data[0], 1);
      idle();
      @(negedge clk);
      check("R6 self clear", rd_data[0], 0);

      step(1, 16'hF806, 3'b0, 2'b01);
      idle();
      @(negedge clk);
      check("R7 halt/kick/vec", {dsp_vec_hi, dsp_halt, dsp_kick}, 3'b111);
      check("R9 top zero", rd_data[15:12], 0);
      step(1, 16'h0600, 3'b0, 2'b10);
      @(negedge clk);
      check("R8 busy mirror", rd_data[10:9], 2'b10);

      for (int c = 0; c < 4000; c++) begin
         logic [15:0] wd;
         wd = 16'($urandom);
         step(($urandom % 4) == 0, wd,
              {($urandom % 7) == 0, ($urandom % 7) == 0, ($urandom % 7) == 0},
              2'($urandom));
      end
      idle();
      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #150000;
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule